// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is the programmable AND plane and fixed OR plane of a small configurable logic device. It takes ten dedicated input signals and eight feedback signals from the output cells. It expands each of these into a true line and a complement line, which gives 36 array lines. It then evaluates 113 product terms against a stored connection pattern. Each product term is the AND of the lines connected to it.

Of the 113 terms, 102 are split into eight unequal groups, and each group is ORed into one sum output. The remaining eleven terms are routed out on their own: eight output-enable terms, a global preset term, a global clear term and a clock term. These outputs feed the separate output-cell logic.

The connection pattern is held in a 113-row by 36-bit configuration store. The store is written one row per clock cycle, and a bulk-erase command opens every connection in one cycle. Evaluation is purely combinational, so outputs follow the inputs in the same cycle. A configuration change becomes visible one clock after it is applied.

Top module: `sop_array`

## Requirements
- R1: Array signal s is `pin_i[s]` for s = 0..9 and `fb_i[s-10]` for s = 10..17. Line 2s carries the true value of signal s and line 2s+1 its complement. Bit L of a configuration row connects line L to that row's product term.
- R2: Each product term is the AND of every line whose connection bit is 1. All outputs are combinational functions of `pin_i`, `fb_i` and the stored pattern, and they settle in the same cycle the inputs change.
- R3: A product term connected to both the true line and the complement line of any one signal is always FALSE, so it never asserts the sum it feeds.
- R4: A product term with no connections set is always TRUE.
- R5: Rows 0..101 are sum terms. `sum_o[k]` is the OR of a contiguous run of rows whose lengths, for k = 0 to 7, are 8, 10, 12, 14, 16, 16, 14 and 12. The runs start at rows 0, 8, 18, 30, 44, 60, 76 and 90.
- R6: Row 102+k drives `oe_o[k]` for k = 0..7. Row 110 drives `preset_o`, row 111 drives `clear_o` and row 112 drives `clk_term_o`.
- R7: When `cfg_we` is high at a rising clock edge, `cfg_data` is stored into row `cfg_row`. The outputs reflect the new row from the following cycle.
- R8: A write with `cfg_row` of 113 or greater changes no row.
- R9: When `cfg_erase` is high at a rising edge, every connection in every row is opened. Erase takes priority over a write in the same cycle.
- R10: Synchronous active-high `rst` leaves the store in the erased state, so every output reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst | input | 1 | Synchronous active-high reset (erases store) |
| cfg_we | input | 1 | Row write strobe |
| cfg_erase | input | 1 | Bulk erase command |
| cfg_row | input | 7 | Row address for a write |
| cfg_data | input | 36 | Connection bits for the addressed row |
| pin_i | input | 10 | Dedicated input signals |
| fb_i | input | 8 | Feedback signals from the output cells |
| sum_o | output | 8 | OR sums of the eight term groups |
| oe_o | output | 8 | Output-enable product terms |
| preset_o | output | 1 | Global preset product term |
| clear_o | output | 1 | Global clear product term |
| clk_term_o | output | 1 | Clock product term |

## Verification
Changes on `pin_i` and `fb_i` reach every output with zero cycles of latency. The bench therefore drives them just after a falling edge and samples one time unit later, inside the same cycle. Writes, erases and reset take effect at the rising edge they are applied on. The programming tasks hold each command across exactly one rising edge and release it at the next falling edge, and the checks sample after that release. This places each check one cycle after the command, when the new row is first visible. The assertions cover the same two latencies: nothing changes without a configuration event or an input change, and erase or reset is fully visible in the cycle after it.

// File: rtl/sop_pkg.sv
package sop_pkg;

    localparam int N_PIN      = 10;
    localparam int N_FB       = 8;
    localparam int N_SIG      = N_PIN + N_FB;
    localparam int N_LINE     = 2 * N_SIG;
    localparam int N_OUT      = 8;
    localparam int N_SUM_PT   = 102;
    localparam int N_CTL_PT   = N_OUT + 3;
    localparam int N_PT       = N_SUM_PT + N_CTL_PT;
    localparam int ROW_W      = $clog2(N_PT);

    localparam int OE_ROW0    = N_SUM_PT;
    localparam int PRESET_ROW = OE_ROW0 + N_OUT;
    localparam int CLEAR_ROW  = PRESET_ROW + 1;
    localparam int CLK_ROW    = CLEAR_ROW + 1;

    // Terms per output: rising by two to the middle, then falling back.
    function automatic int sum_cnt(input int k);
        return (k < 5) ? (8 + 2 * k) : (8 + 2 * (9 - k));
    endfunction

    function automatic int sum_base(input int k);
        int b;
        b = 0;
        for (int j = 0; j < k; j++) b += sum_cnt(j);
        return b;
    endfunction

    typedef struct packed {
        logic [N_OUT-1:0] oe;
        logic             preset;
        logic             clear;
        logic             clk_term;
    } ctl_terms_t;

    typedef struct packed {
        logic             we;
        logic             erase;
        logic [ROW_W-1:0] row;
        logic [N_LINE-1:0] data;
    } cfg_req_t;

endpackage

// File: rtl/sop_cfg_mem.sv
module sop_cfg_mem
    import sop_pkg::*;
#(
    parameter int ROWS  = N_PT,
    parameter int LINES = N_LINE,
    parameter int RW    = ROW_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic                        erase,
    input  logic [RW-1:0]               row,
    input  logic [LINES-1:0]            data,
    output logic [ROWS-1:0][LINES-1:0]  conn
);

    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

    logic                        wr_ok;
    logic [ROWS-1:0][LINES-1:0]  conn_q;

    // Writes only land when the address is legal and no erase is pending.
    assign wr_ok = we && !erase && (row <= LAST_ROW);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic hit;
        assign hit = wr_ok && (row == RW'(r));

        always_ff @(posedge clk) begin
            if (rst || erase) begin
                conn_q[r] <= '0;
            end else if (hit) begin
                conn_q[r] <= data;
            end
        end
    end

    assign conn = conn_q;

endmodule

// File: rtl/sop_line_drv.sv
module sop_line_drv
    import sop_pkg::*;
#(
    parameter int NP = N_PIN,
    parameter int NF = N_FB,
    localparam int NS = NP + NF,
    localparam int NL = 2 * NS
) (
    input  logic [NP-1:0] pin,
    input  logic [NF-1:0] fb,
    output logic [NL-1:0] lines
);

    logic [NS-1:0] sig;

    assign sig = {fb, pin};

    for (genvar s = 0; s < NS; s++) begin : g_sig
        assign lines[2*s]     = sig[s];
        assign lines[2*s + 1] = ~sig[s];
    end

endmodule

// File: rtl/sop_pterm_array.sv
module sop_pterm_array
    import sop_pkg::*;
#(
    parameter int ROWS  = N_PT,
    parameter int LINES = N_LINE
) (
    input  logic [LINES-1:0]            lines,
    input  logic [ROWS-1:0][LINES-1:0]  conn,
    output logic [ROWS-1:0]             pt
);

    // An open crossing forces a 1 into the AND, so an empty row is TRUE.
    for (genvar r = 0; r < ROWS; r++) begin : g_pt
        assign pt[r] = &(lines | ~conn[r]);
    end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane
    import sop_pkg::*;
#(
    parameter int ROWS = N_PT,
    parameter int NO   = N_OUT
) (
    input  logic [ROWS-1:0] pt,
    output logic [NO-1:0]   sum,
    output ctl_terms_t      ctl
);

    for (genvar k = 0; k < NO; k++) begin : g_sum
        localparam int BASE = sum_base(k);
        localparam int CNT  = sum_cnt(k);
        assign sum[k]    = |pt[BASE +: CNT];
        assign ctl.oe[k] = pt[OE_ROW0 + k];
    end

    assign ctl.preset   = pt[PRESET_ROW];
    assign ctl.clear    = pt[CLEAR_ROW];
    assign ctl.clk_term = pt[CLK_ROW];

endmodule

// File: rtl/sop_array.sv
module sop_array
    import sop_pkg::*;
#(
    parameter int NP   = N_PIN,
    parameter int NF   = N_FB,
    parameter int NO   = N_OUT,
    parameter int ROWS = N_PT,
    parameter int RW   = ROW_W,
    localparam int NL  = 2 * (NP + NF)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic          cfg_erase,
    input  logic [RW-1:0] cfg_row,
    input  logic [NL-1:0] cfg_data,
    input  logic [NP-1:0] pin_i,
    input  logic [NF-1:0] fb_i,
    output logic [NO-1:0] sum_o,
    output logic [NO-1:0] oe_o,
    output logic          preset_o,
    output logic          clear_o,
    output logic          clk_term_o
);

    logic [ROWS-1:0][NL-1:0] conn;
    logic [NL-1:0]           lines;
    logic [ROWS-1:0]         pt;
    ctl_terms_t              ctl;

    sop_cfg_mem #(.ROWS(ROWS), .LINES(NL), .RW(RW)) i_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .erase (cfg_erase),
        .row   (cfg_row),
        .data  (cfg_data),
        .conn  (conn)
    );

    sop_line_drv #(.NP(NP), .NF(NF)) i_lines (
        .pin   (pin_i),
        .fb    (fb_i),
        .lines (lines)
    );

    sop_pterm_array #(.ROWS(ROWS), .LINES(NL)) i_and (
        .lines (lines),
        .conn  (conn),
        .pt    (pt)
    );

    sop_or_plane #(.ROWS(ROWS), .NO(NO)) i_or (
        .pt  (pt),
        .sum (sum_o),
        .ctl (ctl)
    );

    assign oe_o       = ctl.oe;
    assign preset_o   = ctl.preset;
    assign clear_o    = ctl.clear;
    assign clk_term_o = ctl.clk_term;

endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk
    import sop_pkg::*;
#(
    parameter int NP   = N_PIN,
    parameter int NF   = N_FB,
    parameter int NO   = N_OUT,
    parameter int ROWS = N_PT,
    parameter int RW   = ROW_W,
    localparam int NL  = 2 * (NP + NF)
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_we,
    input logic          cfg_erase,
    input logic [RW-1:0] cfg_row,
    input logic [NL-1:0] cfg_data,
    input logic [NP-1:0] pin_i,
    input logic [NF-1:0] fb_i,
    input logic [NO-1:0] sum_o,
    input logic [NO-1:0] oe_o,
    input logic          preset_o,
    input logic          clear_o,
    input logic          clk_term_o
);

    localparam logic [RW-1:0] FIRST_BAD = RW'(ROWS);

    logic [2*NO+2:0] outs;
    assign outs = {sum_o, oe_o, preset_o, clear_o, clk_term_o};

    assert_reset_open_R10: assert property (@(posedge clk)
        rst |=> (outs == '1));

    assert_erase_open_R9: assert property (@(posedge clk) disable iff (rst)
        cfg_erase |=> (outs == '1));

    assert_bad_row_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_erase && (cfg_row >= FIRST_BAD)) ##1
        ($stable(pin_i) && $stable(fb_i)) |-> $stable(outs));

    assert_hold_without_change_R2: assert property (@(posedge clk) disable iff (rst)
        (!cfg_we && !cfg_erase) ##1
        ($stable(pin_i) && $stable(fb_i)) |-> $stable(outs));

endmodule

bind sop_array sop_array_chk #(
    .NP(NP), .NF(NF), .NO(NO), .ROWS(ROWS), .RW(RW)
) i_chk (.*);

// File: tb/test_sop_array.sv
module test_sop_array;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we, cfg_erase;
    logic [6:0]  cfg_row;
    logic [35:0] cfg_data;
    logic [9:0]  pin_i;
    logic [7:0]  fb_i;
    logic [7:0]  sum_o, oe_o;
    logic        preset_o, clear_o, clk_term_o;

    int n_checks = 0;
    int n_errors = 0;

    localparam int CNT [8] = '{8, 10, 12, 14, 16, 16, 14, 12};

    always #5 clk = ~clk;

    sop_array i_sop_array (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_erase(cfg_erase),
        .cfg_row(cfg_row), .cfg_data(cfg_data), .pin_i(pin_i), .fb_i(fb_i),
        .sum_o(sum_o), .oe_o(oe_o), .preset_o(preset_o), .clear_o(clear_o),
        .clk_term_o(clk_term_o)
    );

    function automatic int base_of(input int k);
        int b = 0;
        for (int j = 0; j < k; j++) b += CNT[j];
        return b;
    endfunction

    function automatic logic [35:0] tl(input int s);
        logic [35:0] m = '0;
        m[2*s] = 1'b1;
        return m;
    endfunction

    function automatic logic [35:0] cl(input int s);
        logic [35:0] m = '0;
        m[2*s+1] = 1'b1;
        return m;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    task automatic write_row(input int r, input logic [35:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_row = 7'(r); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic erase_all();
        @(negedge clk);
        cfg_erase = 1'b1;
        @(negedge clk);
        cfg_erase = 1'b0;
    endtask

    task automatic kill_rows(input int first, input int last);
        for (int r = first; r <= last; r++) write_row(r, '1);
    endtask

    task automatic t_reset_state();
        pin_i = 10'h155; fb_i = 8'h3C; #1;
        check("R10 sums after reset", sum_o, 8'hFF);
        check("R10 oe after reset", oe_o, 8'hFF);
        check("R4 control terms open", {preset_o, clear_o, clk_term_o}, 3'b111);
    endtask

    task automatic t_and_term();
        erase_all();
        kill_rows(1, 7);
        write_row(0, tl(0) | cl(1));
        for (int p = 0; p < 4; p++) begin
            pin_i = 10'(p); #1;
            check("R2 AND of pin0 and not pin1", 32'(sum_o[0]), 32'(p == 1));
        end
        check("R5 neighbour sum1 untouched", 32'(sum_o[1]), 32'd1);
    endtask

    task automatic t_contradiction();
        write_row(0, tl(2) | cl(2));
        for (int p = 0; p < 2; p++) begin
            pin_i = 10'(p << 2); #1;
            check("R3 true and complement is FALSE", 32'(sum_o[0]), 32'd0);
        end
    endtask

    task automatic t_allocation();
        erase_all();
        kill_rows(0, 101);
        pin_i = '0; fb_i = '0; #1;
        check("R5 all sum rows dead", sum_o, 8'h00);
        for (int k = 0; k < 8; k++) begin
            write_row(base_of(k), '0); #1;
            check("R5 first row of group", sum_o, 32'(1 << k));
            write_row(base_of(k), '1);
            write_row(base_of(k) + CNT[k] - 1, '0); #1;
            check("R5 last row of group", sum_o, 32'(1 << k));
            write_row(base_of(k) + CNT[k] - 1, '1);
        end
    endtask

    task automatic t_control_terms();
        erase_all();
        for (int k = 0; k < 8; k++) write_row(102 + k, tl(10 + k));
        write_row(110, cl(0));
        write_row(111, tl(9));
        write_row(112, tl(3) | tl(4));
        foreach (CNT[i]) begin
            fb_i = 8'(8'hA5 ^ (i * 37)); pin_i = 10'(i * 113); #1;
            check("R6 oe follows feedback", oe_o, fb_i);
            check("R6 preset is not pin0", 32'(preset_o), 32'(!pin_i[0]));
            check("R6 clear is pin9", 32'(clear_o), 32'(pin_i[9]));
            check("R6 clock is pin3 and pin4", 32'(clk_term_o), 32'(pin_i[3] & pin_i[4]));
        end
    endtask

    task automatic t_feedback_sum();
        kill_rows(9, 17);
        write_row(8, cl(17));
        for (int v = 0; v < 2; v++) begin
            fb_i = 8'(v << 7); #1;
            check("R1 sum1 is not fb7", 32'(sum_o[1]), 32'(v == 0));
        end
    endtask

    task automatic t_bad_row();
        erase_all();
        write_row(113, '1);
        write_row(127, '1);
        pin_i = 10'h3FF; fb_i = 8'hFF; #1;
        check("R8 sums after illegal rows", sum_o, 8'hFF);
        check("R8 controls after illegal rows", {oe_o, preset_o, clear_o, clk_term_o}, 11'h7FF);
    endtask

    task automatic t_erase_priority();
        @(negedge clk);
        cfg_we = 1'b1; cfg_erase = 1'b1; cfg_row = 7'd110; cfg_data = '1;
        @(negedge clk);
        cfg_we = 1'b0; cfg_erase = 1'b0; #1;
        check("R9 erase beats write", 32'(preset_o), 32'd1);
        write_row(110, '1); #1;
        check("R7 row write visible next cycle", 32'(preset_o), 32'd0);
        erase_all(); #1;
        check("R9 erase reopens row", 32'(preset_o), 32'd1);
    endtask

    task automatic t_reset_clears();
        write_row(111, '1); #1;
        check("R7 clear row killed", 32'(clear_o), 32'd0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        check("R10 reset erases pattern", 32'(clear_o), 32'd1);
    endtask

    initial begin
        #2_000_000;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_erase = 1'b0;
        cfg_row = '0; cfg_data = '0; pin_i = '0; fb_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_and_term();
        t_contradiction();
        t_allocation();
        t_control_terms();
        t_feedback_sum();
        t_bad_row();
        t_erase_priority();
        t_reset_clears();
        summary();
        $finish;
    end

endmodule